// File: doc/BRIEF.md
# External Bus Priority Arbiter

This block decides, cycle by cycle, which of six masters may drive the single external bus of the chip. Three masters form an urgent tier: the memory refresh engine, the external DMA engine and the bus hold (release) requester. Three form a lower tier: the on-chip DMA controller, the descriptor-transfer engine and the CPU. Each master raises a request bit and a bit saying whether its pending cycle targets external space. It then pulses a done bit when the cycle it was granted completes. Grants move only at those completion points. This lets an urgent master break into a long on-chip DMA burst between beats, and the burst picks up again afterwards.

In dual-address mode a DMA transfer is a read followed by a write. The arbiter counts the DMA completions and keeps the bus with DMA across the read-to-write seam. It opens arbitration only after the write. A DMA cycle whose target is internal space never competes for the external bus. It gets its own internal-lane grant, which can be active while another master owns the external bus. No data moves through the block and there is no stream interface. All pins are plain level or pulse controls.

Top module: `ext_bus_arb`

## Requirements
- R1: While reset is asserted and at the first clock edge after it, no grant output is active: `bus_gnt` is 0 and `dma_int_gnt` is 0.
- R2: When arbitration is open and no master has an eligible request, the CPU receives a parked grant (`bus_gnt` bit 5). A parked grant can be taken away at any clock edge.
- R3: At an open arbitration edge the grant goes to the eligible requester with the lowest bit index. The bit order is refresh 0, external DMA 1, hold 2, on-chip DMA 3, descriptor engine 4, CPU 5. A request is eligible when its `bus_req` and `bus_ext` bits are both 1.
- R4: Once a master other than hold owns the bus on a real request, `bus_gnt` does not change until that master's `cyc_done` bit is sampled high. New requests of any priority wait until then.
- R5: At a single-mode on-chip DMA beat boundary, a pending urgent-tier request takes the bus from DMA. If DMA is still requesting when that cycle ends, DMA is granted again.
- R6: With `dma_dual` high, the first DMA completion (the read) leaves the grant with DMA. Only the second completion (the write) opens arbitration.
- R7: The hold grant stays active for as long as `bus_req[2]` stays high, and its `cyc_done` bit is ignored. At the first edge where `bus_req[2]` is sampled low, arbitration opens.
- R8: The descriptor engine and the CPU do not win while on-chip DMA keeps requesting. At each DMA boundary DMA is granted again ahead of them.
- R9: An on-chip DMA request with `bus_ext[3]` low raises `dma_int_gnt` at the next edge. This can happen while another master holds `bus_gnt`. `dma_int_gnt` clears at the edge where `cyc_done[3]` is sampled high.
- R10: A request from a master other than on-chip DMA whose `bus_ext` bit is low is ignored: it produces no grant.
- R11: `bus_gnt` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 6 | Request per master (bit 0 refresh … bit 5 CPU) |
| bus_ext | input | 6 | Pending cycle of each master targets external space |
| cyc_done | input | 6 | One-cycle pulse: granted cycle of that master completes |
| dma_dual | input | 1 | On-chip DMA runs dual-address read/write pairs |
| bus_gnt | output | 6 | One-hot external bus grant, registered |
| dma_int_gnt | output | 1 | On-chip DMA granted an internal-space cycle, registered |

## Verification
A corrupted ownership flag shows as a grant that moves in the middle of a cycle or refuses to move at a boundary. Either is visible on `bus_gnt` at the very next edge after the offending done pulse or request change. A wrong pair-phase bit makes a dual-address read and write split. The bus then leaves DMA one completion early, or stays one completion too long, on the edge after the read pulse. A stuck internal-lane flag shows on `dma_int_gnt` one edge after the done pulse. It can also appear as DMA winning the external bus while its internal grant is still up.

// File: rtl/ext_bus_arb_pkg.sv
package ext_bus_arb_pkg;
  localparam int NMST    = 6;
  localparam int M_RFSH  = 0;
  localparam int M_XDMA  = 1;
  localparam int M_HOLD  = 2;
  localparam int M_DMA   = 3;
  localparam int M_DESC  = 4;
  localparam int M_CPU   = 5;
  typedef logic [NMST-1:0] mvec_t;
  localparam mvec_t PARK_VEC = mvec_t'(1) << M_CPU;
endpackage

// File: rtl/ext_bus_arb_pick.sv
module ext_bus_arb_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] win,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | cand[i];
    assign win[i]       = cand[i] & ~blocked[i];
  end
  assign any = blocked[N];
endmodule

// File: rtl/ext_bus_arb_pair.sv
module ext_bus_arb_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic xfer_done,
  output logic pair_ok,
  output logic phase
);
  // phase 0: next completion is a read; phase 1: next completion is the write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= 1'b0;
    else if (xfer_done && dual) phase <= ~phase;
  end
  assign pair_ok = ~dual | phase;
endmodule

// File: rtl/ext_bus_arb_lane.sv
module ext_bus_arb_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ext,
  input  logic done,
  input  logic ext_owned,
  output logic int_gnt
);
  logic start;
  assign start = req & ~ext & ~ext_owned;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       int_gnt <= 1'b0;
    else if (int_gnt) int_gnt <= ~done;
    else              int_gnt <= start;
  end
endmodule

// File: rtl/ext_bus_arb.sv
module ext_bus_arb
  import ext_bus_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMST-1:0] bus_req,
  input  logic [NMST-1:0] bus_ext,
  input  logic [NMST-1:0] cyc_done,
  input  logic            dma_dual,
  output logic [NMST-1:0] bus_gnt,
  output logic            dma_int_gnt
);
  mvec_t gnt_q, cand, win, dma_mask;
  logic  busy_q, any, open, cyc_end, dma_xdone, pair_ok, phase;

  assign dma_mask  = mvec_t'(1) << M_DMA;
  assign cand      = bus_req & bus_ext & ~(dma_int_gnt ? dma_mask : '0);
  assign dma_xdone = busy_q & gnt_q[M_DMA] & cyc_done[M_DMA];

  always_comb begin
    if (gnt_q[M_HOLD])     cyc_end = ~bus_req[M_HOLD];
    else if (gnt_q[M_DMA]) cyc_end = cyc_done[M_DMA] & pair_ok;
    else                   cyc_end = |(gnt_q & cyc_done);
  end
  assign open = ~busy_q | cyc_end;

  ext_bus_arb_pick #(.N(NMST)) pick_i (
    .cand (cand),
    .win  (win),
    .any  (any)
  );

  ext_bus_arb_pair pair_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual      (dma_dual),
    .xfer_done (dma_xdone),
    .pair_ok   (pair_ok),
    .phase     (phase)
  );

  ext_bus_arb_lane lane_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req[M_DMA]),
    .ext       (bus_ext[M_DMA]),
    .done      (cyc_done[M_DMA]),
    .ext_owned (busy_q & gnt_q[M_DMA]),
    .int_gnt   (dma_int_gnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (open) begin
      gnt_q  <= any ? win : PARK_VEC;
      busy_q <= any;
    end
  end

  assign bus_gnt = gnt_q;
endmodule

// File: rtl/ext_bus_arb_chk.sv
module ext_bus_arb_chk
  import ext_bus_arb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NMST-1:0] bus_req,
  input logic [NMST-1:0] bus_ext,
  input logic [NMST-1:0] cyc_done,
  input logic            dma_dual,
  input logic [NMST-1:0] bus_gnt,
  input logic            dma_int_gnt,
  input logic            busy,
  input logic            phase
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (bus_gnt == '0 && !dma_int_gnt));
  // R11
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bus_gnt));
  // R4
  held_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_gnt[M_HOLD] && ((bus_gnt & cyc_done) == '0) |=> $stable(bus_gnt));
  // R6
  pair_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_gnt[M_DMA] && cyc_done[M_DMA] && dma_dual && !phase |=> bus_gnt[M_DMA]);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt[M_HOLD] && bus_req[M_HOLD] |=> bus_gnt[M_HOLD]);
  // R9
  int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_int_gnt && !cyc_done[M_DMA] |=> dma_int_gnt);
  // R9
  int_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_int_gnt |-> !bus_gnt[M_DMA]);
  // R10
  eligible_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_gnt) && bus_gnt != '0 && !bus_gnt[M_CPU] |->
      (bus_gnt & $past(bus_req & bus_ext)) != '0);
endmodule

bind ext_bus_arb ext_bus_arb_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_ext     (bus_ext),
  .cyc_done    (cyc_done),
  .dma_dual    (dma_dual),
  .bus_gnt     (bus_gnt),
  .dma_int_gnt (dma_int_gnt),
  .busy        (busy_q),
  .phase       (phase)
);

// File: tb/ext_bus_arb_tb_top.sv
module ext_bus_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_req = '0, bus_ext = '0, cyc_done = '0;
  logic       dma_dual = 1'b0;
  logic [5:0] bus_gnt;
  logic       dma_int_gnt;
  int         nvec = 0, nbad = 0;

  always #4 clk = ~clk;  // 125 MHz

  ext_bus_arb dut_i (
    .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_ext (bus_ext),
    .cyc_done (cyc_done), .dma_dual (dma_dual), .bus_gnt (bus_gnt),
    .dma_int_gnt (dma_int_gnt)
  );

  // fields: tag[4], req[6], ext[6], done[6], dual, exp_gnt[6], exp_int
  localparam int NV = 37;
  localparam logic [29:0] VEC [NV] = '{
    {4'd2,  6'b000000, 6'b111111, 6'b000000, 1'b0, 6'b100000, 1'b0}, // R2 park
    {4'd3,  6'b000011, 6'b111111, 6'b000000, 1'b0, 6'b000001, 1'b0}, // R3
    {4'd4,  6'b001011, 6'b111111, 6'b000000, 1'b0, 6'b000001, 1'b0}, // R4
    {4'd3,  6'b001010, 6'b111111, 6'b000001, 1'b0, 6'b000010, 1'b0}, // R3
    {4'd3,  6'b001000, 6'b111111, 6'b000010, 1'b0, 6'b001000, 1'b0}, // R3
    {4'd4,  6'b001001, 6'b111111, 6'b000000, 1'b0, 6'b001000, 1'b0}, // R4
    {4'd5,  6'b001001, 6'b111111, 6'b001000, 1'b0, 6'b000001, 1'b0}, // R5 preempt
    {4'd5,  6'b001000, 6'b111111, 6'b000001, 1'b0, 6'b001000, 1'b0}, // R5 resume
    {4'd8,  6'b011000, 6'b111111, 6'b001000, 1'b0, 6'b001000, 1'b0}, // R8
    {4'd8,  6'b011000, 6'b111111, 6'b001000, 1'b0, 6'b001000, 1'b0}, // R8
    {4'd8,  6'b010000, 6'b111111, 6'b001000, 1'b0, 6'b010000, 1'b0}, // R8
    {4'd2,  6'b000000, 6'b111111, 6'b010000, 1'b0, 6'b100000, 1'b0}, // R2
    {4'd6,  6'b001000, 6'b111111, 6'b000000, 1'b1, 6'b001000, 1'b0}, // R6
    {4'd6,  6'b001001, 6'b111111, 6'b001000, 1'b1, 6'b001000, 1'b0}, // R6 read
    {4'd6,  6'b001001, 6'b111111, 6'b001000, 1'b1, 6'b000001, 1'b0}, // R6 write
    {4'd6,  6'b001000, 6'b111111, 6'b000001, 1'b1, 6'b001000, 1'b0}, // R6
    {4'd6,  6'b001000, 6'b111111, 6'b000000, 1'b1, 6'b001000, 1'b0}, // R6
    {4'd6,  6'b001000, 6'b111111, 6'b001000, 1'b1, 6'b001000, 1'b0}, // R6 read
    {4'd6,  6'b000000, 6'b111111, 6'b001000, 1'b1, 6'b100000, 1'b0}, // R6 write
    {4'd7,  6'b000100, 6'b111111, 6'b000000, 1'b0, 6'b000100, 1'b0}, // R7
    {4'd7,  6'b000101, 6'b111111, 6'b000100, 1'b0, 6'b000100, 1'b0}, // R7
    {4'd7,  6'b000101, 6'b111111, 6'b000000, 1'b0, 6'b000100, 1'b0}, // R7
    {4'd7,  6'b000001, 6'b111111, 6'b000000, 1'b0, 6'b000001, 1'b0}, // R7 release
    {4'd2,  6'b000000, 6'b111111, 6'b000001, 1'b0, 6'b100000, 1'b0}, // R2
    {4'd9,  6'b001001, 6'b110111, 6'b000000, 1'b0, 6'b000001, 1'b1}, // R9
    {4'd9,  6'b001001, 6'b110111, 6'b001000, 1'b0, 6'b000001, 1'b0}, // R9
    {4'd9,  6'b001000, 6'b110111, 6'b000001, 1'b0, 6'b100000, 1'b1}, // R9
    {4'd9,  6'b000000, 6'b111111, 6'b001000, 1'b0, 6'b100000, 1'b0}, // R9
    {4'd10, 6'b110111, 6'b000000, 6'b000000, 1'b0, 6'b100000, 1'b0}, // R10
    {4'd10, 6'b010000, 6'b000000, 6'b000000, 1'b0, 6'b100000, 1'b0}, // R10
    {4'd10, 6'b010000, 6'b010000, 6'b000000, 1'b0, 6'b010000, 1'b0}, // R10
    {4'd2,  6'b000000, 6'b111111, 6'b010000, 1'b0, 6'b100000, 1'b0}, // R2
    {4'd3,  6'b100001, 6'b111111, 6'b000000, 1'b0, 6'b000001, 1'b0}, // R3
    {4'd3,  6'b100000, 6'b111111, 6'b000001, 1'b0, 6'b100000, 1'b0}, // R3
    {4'd4,  6'b100001, 6'b111111, 6'b000000, 1'b0, 6'b100000, 1'b0}, // R4
    {4'd3,  6'b000001, 6'b111111, 6'b100000, 1'b0, 6'b000001, 1'b0}, // R3
    {4'd2,  6'b000000, 6'b111111, 6'b000001, 1'b0, 6'b100000, 1'b0}  // R2
  };

  task automatic check(input int tag, input logic [6:0] act, input logic [6:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL R%0d: got gnt=%b int=%b, expected gnt=%b int=%b",
               tag, act[6:1], act[0], exp[6:1], exp[0]);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin : main
    repeat (3) @(posedge clk);
    // R1: outputs idle during reset
    check(1, {bus_gnt, dma_int_gnt}, 7'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(1, {bus_gnt, dma_int_gnt}, 7'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_req  = VEC[i][25:20];
      bus_ext  = VEC[i][19:14];
      cyc_done = VEC[i][13:8];
      dma_dual = VEC[i][7];
      @(posedge clk);
      #1;
      check(int'(VEC[i][29:26]), {bus_gnt, dma_int_gnt}, VEC[i][6:0]);
      // R11: grant vector never has two owners
      check(11, {5'b0, ($countones(bus_gnt) > 1), 1'b0}, 7'b0);
    end

    // R1: reset taken while DMA owns the bus and the internal lane is idle
    @(negedge clk);
    bus_req = 6'b001000; bus_ext = 6'b111111; cyc_done = '0; dma_dual = 1'b0;
    @(posedge clk); #1;
    check(3, {bus_gnt, dma_int_gnt}, {6'b001000, 1'b0});
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(1, {bus_gnt, dma_int_gnt}, 7'b0);
    @(negedge clk);
    bus_req = '0;
    rst_n = 1'b1;
    #1 check(1, {bus_gnt, dma_int_gnt}, 7'b0);
    @(posedge clk); #1;
    check(2, {bus_gnt, dma_int_gnt}, {6'b100000, 1'b0});

    finish_run();
  end
endmodule